// File: doc/BRIEF.md
# Multiplexed-Bus Register Address Decoder

This block sits on the host side of a dual-channel peripheral that shares one 8-bit bus for address and data. When the address strobe returns high, the block captures the bus byte. It splits that byte into a 4-bit register index and a channel flag, and it holds the result until the next address strobe. While the data strobe is low, it raises exactly one read or write select for the addressed register. The register file and the serial engines live elsewhere and consume these selects.

Two bit layouts are supported. In the default layout, bit 5 carries the channel and bits 4..1 carry the index, so software can walk one channel's registers in a row. In the alternate layout, bit 0 carries the channel, so consecutive addresses hit the same register in channel B and then channel A. The layout is switched by a command written to channel B register 0. Address byte 0x00 reaches that register in both layouts, which is why the switch always works.

Two write registers exist only once, and a write from either channel lands in that single copy. Read indices with no physical register behind them fold onto registers that do exist.

Top module: `mux_reg_addr_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `shift_right` is 0, `addr_valid` is 0 and every select output is 0. A reset during operation returns the block to the default layout.
- R2: The address is captured only on a clock edge where `as_n` is seen high after having been low on the previous edge. `addr_valid` takes the inverse of `cs_n` at that edge. The captured index, channel and valid flag do not change on any other edge.
- R3: With `shift_right`=0, the captured index is `ad[4:1]`, and the channel is A when `ad[5]`=1 and B when `ad[5]`=0.
- R4: With `shift_right`=1, the captured index is `ad[4:1]`, and the channel is A when `ad[0]`=1 and B when `ad[0]`=0. Addresses 2k and 2k+1 therefore reach the same register in channel B and then channel A.
- R5: A mode command takes effect on the first edge of `ds_n` going low, during a write (`rw`=0) to captured index 0, channel B, with `addr_valid`=1. If `ad[1:0]`=01 it selects the default layout (`shift_right`=0), and if `ad[1:0]`=10 it selects the alternate layout (`shift_right`=1). The values 00 and 11, reads, and writes to channel A register 0 leave the mode unchanged. The new mode is visible one cycle later.
- R6: Write select bit `i` of `wr_sel_a` or `wr_sel_b` is high only while `addr_valid`=1, `ds_n`=0 and `rw`=0 with captured index `i`. `wr_sel_a` is used for channel A and `wr_sel_b` for channel B.
- R7: Writes to index 2 or index 9 raise `wr_sel_a[2]` or `wr_sel_a[9]` whatever the channel. `wr_sel_b[2]` and `wr_sel_b[9]` never go high.
- R8: Read selects go high only while `addr_valid`=1, `ds_n`=0 and `rw`=1. Indices 4, 5, 6, 7, 9, 11 and 14 fold onto 0, 1, 2, 3, 13, 15 and 10, so no read select bit at those seven positions ever goes high.
- R9: At most one bit across all four select vectors is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples all bus inputs |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ad | input | 8 | Multiplexed address/data bus |
| as_n | input | 1 | Address strobe, active low; the rising edge captures the address |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | Direction: 1 = read, 0 = write |
| cs_n | input | 1 | Chip select, active low, sampled at the address capture |
| shift_right | output | 1 | Current layout: 0 = channel in bit 5, 1 = channel in bit 0 |
| addr_valid | output | 1 | Captured address was selected |
| reg_idx | output | 4 | Captured register index |
| chan_a | output | 1 | Captured channel: 1 = A, 0 = B |
| wr_sel_a | output | 16 | One-hot write select for channel A and the shared registers |
| wr_sel_b | output | 16 | One-hot write select for channel B |
| rd_sel_a | output | 16 | One-hot read select for channel A after folding |
| rd_sel_b | output | 16 | One-hot read select for channel B after folding |

## Verification
The bench walks all 32 index/channel pairs in both layouts, for writes and for reads. A decoder that takes the channel from the wrong bit would mismatch on every channel-A access in one of the two modes. The bench sends mode commands with all four data codes, through channel A register 0 and through a read. A design that decodes the command loosely would flip layouts, and every later access would then land on the wrong channel. Writes from channel B to the two shared indices, and reads of the seven folded indices, catch a design that keeps a second copy or selects a missing register. A deselected address cycle and a reset in the middle of the run catch a latch that ignores chip select or a mode that survives reset.

// File: rtl/mux_dec_pkg.sv
package mux_dec_pkg;
  localparam int AD_W           = 8;
  localparam int NREG           = 16;
  localparam int IDX_W          = $clog2(NREG);
  localparam int IDX_LSB        = 1;
  localparam int CHAN_BIT_LEFT  = 5;
  localparam int CHAN_BIT_RIGHT = 0;
  localparam int SHARED_WR_LO   = 2;
  localparam int SHARED_WR_HI   = 9;

  typedef logic [AD_W-1:0]  bus_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [NREG-1:0]  sel_t;

  typedef enum logic [1:0] {
    MCMD_NONE  = 2'b00,
    MCMD_LEFT  = 2'b01,
    MCMD_RIGHT = 2'b10,
    MCMD_RSVD  = 2'b11
  } mode_cmd_e;

  function automatic idx_t bus_index(bus_t b);
    return b[IDX_LSB +: IDX_W];
  endfunction

  function automatic logic bus_chan_a(bus_t b, logic right);
    return right ? b[CHAN_BIT_RIGHT] : b[CHAN_BIT_LEFT];
  endfunction

  function automatic mode_cmd_e bus_mode_cmd(bus_t b);
    return mode_cmd_e'(b[1:0]);
  endfunction

  function automatic logic wr_is_shared(idx_t i);
    return (i == idx_t'(SHARED_WR_LO)) || (i == idx_t'(SHARED_WR_HI));
  endfunction

  function automatic idx_t rd_fold(idx_t i);
    case (i)
      idx_t'(4):  return idx_t'(0);
      idx_t'(5):  return idx_t'(1);
      idx_t'(6):  return idx_t'(2);
      idx_t'(7):  return idx_t'(3);
      idx_t'(9):  return idx_t'(13);
      idx_t'(11): return idx_t'(15);
      idx_t'(14): return idx_t'(10);
      default:    return i;
    endcase
  endfunction

  function automatic sel_t rd_missing_mask();
    sel_t m;
    for (int k = 0; k < NREG; k++) m[k] = (rd_fold(idx_t'(k)) != idx_t'(k));
    return m;
  endfunction
endpackage

// File: rtl/mux_addr_latch.sv
module mux_addr_latch
  import mux_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  bus_t ad,
  input  logic as_n,
  input  logic cs_n,
  input  logic shift_right,
  output logic as_rise,
  output logic lat_valid,
  output idx_t lat_idx,
  output logic lat_chan_a
);
  logic as_q;

  assign as_rise = as_n & ~as_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q       <= 1'b1;
      lat_valid  <= 1'b0;
      lat_idx    <= '0;
      lat_chan_a <= 1'b0;
    end else begin
      as_q <= as_n;
      if (as_rise) begin
        lat_valid  <= ~cs_n;
        lat_idx    <= bus_index(ad);
        lat_chan_a <= bus_chan_a(ad, shift_right);
      end
    end
  end

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !as_rise |=> ($stable(lat_idx) && $stable(lat_valid) && $stable(lat_chan_a)));

  // R2
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (as_rise && cs_n) |=> !lat_valid);

  // R3
  left_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (as_rise && !shift_right) |=> (lat_chan_a == $past(ad[5])));

  // R4
  right_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (as_rise && shift_right) |=> (lat_chan_a == $past(ad[0])));
endmodule

// File: rtl/mux_shift_mode.sv
module mux_shift_mode
  import mux_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  bus_t ad,
  input  logic ds_n,
  input  logic rw,
  input  logic lat_valid,
  input  idx_t lat_idx,
  input  logic lat_chan_a,
  output logic cmd_hit,
  output logic shift_right
);
  logic ds_q;
  logic ds_fall;

  assign ds_fall = ~ds_n & ds_q;
  assign cmd_hit = ds_fall & lat_valid & ~rw & ~lat_chan_a & (lat_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q        <= 1'b1;
      shift_right <= 1'b0;
    end else begin
      ds_q <= ds_n;
      if (cmd_hit) begin
        case (bus_mode_cmd(ad))
          MCMD_LEFT:  shift_right <= 1'b0;
          MCMD_RIGHT: shift_right <= 1'b1;
          default:    shift_right <= shift_right;
        endcase
      end
    end
  end

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_hit |=> $stable(shift_right));

  // R5
  mode_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && ad[1:0] == 2'b10) |=> shift_right);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_left_chk: assert (!shift_right);
    end
  end
endmodule

// File: rtl/mux_sel_decode.sv
module mux_sel_decode
  import mux_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lat_valid,
  input  idx_t lat_idx,
  input  logic lat_chan_a,
  input  logic ds_n,
  input  logic rw,
  output sel_t wr_sel_a,
  output sel_t wr_sel_b,
  output sel_t rd_sel_a,
  output sel_t rd_sel_b
);
  localparam sel_t RD_MISSING = rd_missing_mask();

  logic wr_en;
  logic rd_en;
  logic wr_tgt_a;
  idx_t rd_idx;

  assign wr_en    = lat_valid & ~ds_n & ~rw;
  assign rd_en    = lat_valid & ~ds_n & rw;
  assign wr_tgt_a = lat_chan_a | wr_is_shared(lat_idx);
  assign rd_idx   = rd_fold(lat_idx);

  for (genvar r = 0; r < NREG; r++) begin : g_sel
    logic wr_hit;
    logic rd_hit;
    assign wr_hit      = (lat_idx == idx_t'(r));
    assign rd_hit      = (rd_idx == idx_t'(r));
    assign wr_sel_a[r] = wr_en & wr_tgt_a & wr_hit;
    assign wr_sel_b[r] = wr_en & ~wr_tgt_a & wr_hit;
    assign rd_sel_a[r] = rd_en & lat_chan_a & rd_hit;
    assign rd_sel_b[r] = rd_en & ~lat_chan_a & rd_hit;
  end

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_sel_a, wr_sel_b, rd_sel_a, rd_sel_b}));

  // R6
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|{wr_sel_a, wr_sel_b}) |-> (!ds_n && !rw && lat_valid));

  // R7
  shared_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_valid && !ds_n && !rw && (lat_idx == idx_t'(SHARED_WR_LO) || lat_idx == idx_t'(SHARED_WR_HI)))
      |-> (wr_sel_a[lat_idx] && !wr_sel_b[lat_idx]));

  // R8
  rd_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((rd_sel_a | rd_sel_b) & RD_MISSING) == '0) && ((|{rd_sel_a, rd_sel_b}) -> (!ds_n && rw)));
endmodule

// File: rtl/mux_reg_addr_decoder.sv
module mux_reg_addr_decoder
  import mux_dec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AD_W-1:0]       ad,
  input  logic                  as_n,
  input  logic                  ds_n,
  input  logic                  rw,
  input  logic                  cs_n,
  output logic                  shift_right,
  output logic                  addr_valid,
  output logic [IDX_W-1:0]      reg_idx,
  output logic                  chan_a,
  output logic [NREG-1:0]       wr_sel_a,
  output logic [NREG-1:0]       wr_sel_b,
  output logic [NREG-1:0]       rd_sel_a,
  output logic [NREG-1:0]       rd_sel_b
);
  logic as_rise;
  logic cmd_hit;
  logic lat_valid;
  idx_t lat_idx;
  logic lat_chan_a;
  logic mode_right;

  mux_addr_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad         (ad),
    .as_n       (as_n),
    .cs_n       (cs_n),
    .shift_right(mode_right),
    .as_rise    (as_rise),
    .lat_valid  (lat_valid),
    .lat_idx    (lat_idx),
    .lat_chan_a (lat_chan_a)
  );

  mux_shift_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad         (ad),
    .ds_n       (ds_n),
    .rw         (rw),
    .lat_valid  (lat_valid),
    .lat_idx    (lat_idx),
    .lat_chan_a (lat_chan_a),
    .cmd_hit    (cmd_hit),
    .shift_right(mode_right)
  );

  mux_sel_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_valid  (lat_valid),
    .lat_idx    (lat_idx),
    .lat_chan_a (lat_chan_a),
    .ds_n       (ds_n),
    .rw         (rw),
    .wr_sel_a   (wr_sel_a),
    .wr_sel_b   (wr_sel_b),
    .rd_sel_a   (rd_sel_a),
    .rd_sel_b   (rd_sel_b)
  );

  assign shift_right = mode_right;
  assign addr_valid  = lat_valid;
  assign reg_idx     = lat_idx;
  assign chan_a      = lat_chan_a;

  // R5
  cmd_needs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |-> !as_rise);
endmodule

// File: tb/test_mux_reg_addr_decoder.sv
module test_mux_reg_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [7:0]  ad = 8'h00;
  logic        as_n = 1'b1, ds_n = 1'b1, rw = 1'b1, cs_n = 1'b1;
  logic        shift_right, addr_valid, chan_a;
  logic [3:0]  reg_idx;
  logic [15:0] wr_sel_a, wr_sel_b, rd_sel_a, rd_sel_b;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  mux_reg_addr_decoder i_mux_reg_addr_decoder (.*);

  always #5 clk = ~clk;

  // reference model state
  bit m_as_q = 1, m_ds_q = 1, m_mode = 0, m_valid = 0, m_cha = 0;
  int m_idx = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int fold(int i);
    if (i >= 4 && i <= 7) return i - 4;
    if (i == 9) return 13;
    if (i == 11) return 15;
    if (i == 14) return 10;
    return i;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_as_q = 1; m_ds_q = 1; m_mode = 0; m_valid = 0; m_cha = 0; m_idx = 0;
    end else begin
      bit rise, fall, cmd, nmode;
      rise = as_n && !m_as_q;
      fall = !ds_n && m_ds_q;
      cmd  = fall && m_valid && !rw && m_idx == 0 && !m_cha;
      nmode = m_mode;
      if (cmd && ad[1:0] == 2'b01) nmode = 0;
      if (cmd && ad[1:0] == 2'b10) nmode = 1;
      if (rise) begin
        m_valid = !cs_n;
        m_idx   = (ad / 2) % 16;
        m_cha   = m_mode ? ad[0] : ad[5];
      end
      m_mode = nmode;
      m_as_q = as_n;
      m_ds_q = ds_n;
    end
    #2;
    if (rst_n) begin
      logic [15:0] ewa, ewb, era, erb;
      ewa = 0; ewb = 0; era = 0; erb = 0;
      if (m_valid && !ds_n && !rw) begin
        if (m_cha || m_idx == 2 || m_idx == 9) ewa[m_idx] = 1'b1;
        else ewb[m_idx] = 1'b1;
      end
      if (m_valid && !ds_n && rw) begin
        if (m_cha) era[fold(m_idx)] = 1'b1;
        else erb[fold(m_idx)] = 1'b1;
      end
      chk("R5 shift_right", 64'(shift_right), 64'(m_mode));
      chk("R2 addr_valid", 64'(addr_valid), 64'(m_valid));
      chk("R3 reg_idx", 64'(reg_idx), 64'(m_idx));
      chk("R4 chan_a", 64'(chan_a), 64'(m_cha));
      chk("R6 wr_sel_a", 64'(wr_sel_a), 64'(ewa));
      chk("R7 wr_sel_b", 64'(wr_sel_b), 64'(ewb));
      chk("R8 rd_sel_a", 64'(rd_sel_a), 64'(era));
      chk("R8 rd_sel_b", 64'(rd_sel_b), 64'(erb));
      chk("R9 onehot", 64'($countones({wr_sel_a, wr_sel_b, rd_sel_a, rd_sel_b}) <= 1), 64'(1));
    end
  end

  task automatic bus(input logic [7:0] addr, input logic rd, input logic [7:0] data, input logic sel);
    @(negedge clk); ad = addr; as_n = 0; cs_n = !sel; rw = rd;
    @(negedge clk); as_n = 1;
    @(negedge clk); ad = data; ds_n = 0;
    @(negedge clk);
    @(negedge clk); ds_n = 1; cs_n = 1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1 rst_n = 0;
    idle(3);
    // R1 reset state
    chk("R1 mode at reset", 64'(shift_right), 64'(0));
    chk("R1 valid at reset", 64'(addr_valid), 64'(0));
    chk("R1 selects at reset", 64'({wr_sel_a, wr_sel_b, rd_sel_a, rd_sel_b}), 64'(0));
    rst_n = 1;
    idle(2);
    // R3 default layout: walk both channels, writes then reads
    for (int i = 0; i < 32; i++) begin
      bus(8'(i * 2), 1'b0, 8'h00, 1'b1);
      chk("R3 left idx", 64'(reg_idx), 64'(i % 16));
      chk("R3 left chan", 64'(chan_a), 64'(i / 16));
    end
    for (int i = 0; i < 32; i++) bus(8'(i * 2), 1'b1, 8'h02, 1'b1);
    // R2 deselected cycle
    bus(8'h24, 1'b0, 8'h00, 1'b0);
    chk("R2 deselected", 64'(addr_valid), 64'(0));
    // R5 channel A reg 0 command in default layout ignored
    bus(8'h20, 1'b0, 8'h02, 1'b1);
    chk("R5 WR0A ignored", 64'(shift_right), 64'(0));
    // R5 switch to alternate layout
    bus(8'h00, 1'b0, 8'h02, 1'b1);
    chk("R5 to right", 64'(shift_right), 64'(1));
    // R4 alternate layout: consecutive addresses alternate channels
    for (int i = 0; i < 32; i++) begin
      bus(8'(i), 1'b0, 8'h00, 1'b1);
      chk("R4 right idx", 64'(reg_idx), 64'(i / 2));
      chk("R4 right chan", 64'(chan_a), 64'(i % 2));
    end
    for (int i = 0; i < 32; i++) bus(8'(i), 1'b1, 8'h01, 1'b1);
    // R5 ignored commands
    bus(8'h01, 1'b0, 8'h01, 1'b1);
    chk("R5 WR0A ignored right", 64'(shift_right), 64'(1));
    bus(8'h00, 1'b0, 8'h03, 1'b1);
    chk("R5 code 11 ignored", 64'(shift_right), 64'(1));
    bus(8'h00, 1'b0, 8'h00, 1'b1);
    chk("R5 code 00 ignored", 64'(shift_right), 64'(1));
    bus(8'h00, 1'b1, 8'h01, 1'b1);
    chk("R5 read ignored", 64'(shift_right), 64'(1));
    bus(8'h00, 1'b0, 8'h01, 1'b0);
    chk("R5 deselected ignored", 64'(shift_right), 64'(1));
    // R5 back to default layout
    bus(8'h00, 1'b0, 8'h01, 1'b1);
    chk("R5 to left", 64'(shift_right), 64'(0));
    // R7 shared writes from channel B
    bus(8'h04, 1'b0, 8'h00, 1'b1);
    bus(8'h12, 1'b0, 8'h00, 1'b1);
    // R1 reset mid-run restores default layout
    bus(8'h00, 1'b0, 8'h02, 1'b1);
    chk("R5 right again", 64'(shift_right), 64'(1));
    rst_n = 0;
    idle(2);
    chk("R1 mid-run reset", 64'({shift_right, addr_valid}), 64'(0));
    rst_n = 1;
    idle(3);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule